// File: doc/BRIEF.md
# Dual-Mode Global-History Branch Direction Predictor

This block predicts the direction of conditional branches from a table of 2-bit up/down saturating counters. Each request picks one counter with an index formed from the branch address and a global history register. The counter's upper bit is the predicted direction. The block then trains that counter with the resolved outcome and shifts the outcome into the history.

Each request carries a mode bit. In forward mode the caller already knows the real outcome and gets back whether the prediction matched it. In inverse mode the caller knows only whether the prediction matched, and the block rebuilds the real outcome from that. Both modes train the counter and the history in exactly the same way. An encoder running forward mode and a decoder running inverse mode therefore hold identical tables at every step.

The table is a synchronous RAM. Each request does a two-cycle read-modify-write on it. A controller with three states sequences the work:
- `ST_WIPE` zeroes one entry per cycle after reset or a clear.
- `ST_IDLE` holds no request in flight.
- `ST_LOOK` resolves and writes back the request accepted in the previous cycle.

The transitions are:
- *wipe-done*: `ST_WIPE` to `ST_IDLE` after the last entry is written.
- *accept*: `ST_IDLE` to `ST_LOOK`.
- *chain*: `ST_LOOK` to `ST_LOOK` when another request is accepted while one resolves.
- *drain*: `ST_LOOK` to `ST_IDLE` when no request is accepted.
- *clear*: from any state to `ST_WIPE` whenever `clr_i` is high.

Top module: `bp_gshare_dual`

## Requirements
- R1: Reset and a `clr_i` pulse each start a walk that writes zero to every counter, one entry per cycle. `req_ready_o` stays low for exactly 2^IDX_W cycles, counted from the first clock edge after reset is released or after `clr_i` is sampled. After the walk every counter reads as 0.
- R2: The table index is the low IDX_W bits of (PC >> 2) XOR (history << 2). The history used is the value after every earlier accepted request has been applied.
- R3: The predicted direction is bit 1 of the counter. An outcome of 1 (taken) increments the counter, saturating at 3. An outcome of 0 decrements it, saturating at 0.
- R4: In forward mode (`req_mode_i` = 0), `req_bit_i` is the real outcome, and `rsp_bit_o` is 1 exactly when the predicted direction equals it.
- R5: In inverse mode (`req_mode_i` = 1), `req_bit_i` is the hit flag. The outcome is 1 exactly when the predicted direction equals the hit flag. That outcome is returned on `rsp_bit_o` and is used to train the counter.
- R6: After each resolved request the HIST_W-bit history shifts left by one and takes the outcome into bit 0. A clear sets it to zero.
- R7: An accepted request (`req_valid_i` and `req_ready_o` high at a clock edge) gives exactly one response. It appears as a one-cycle `rsp_valid_o` pulse after the second clock edge that follows the accepting edge.
- R8: While a request resolves, a new request whose index equals the in-flight index is held off with `req_ready_o` low. A new request with a different index is accepted in the very next cycle.
- R9: A request presented while `req_ready_o` is low is neither answered nor used for training.
- R10: `clr_i` takes priority over everything else. A request still resolving when `clr_i` is sampled gives no response and leaves no trace in the table.
- R11: Feeding inverse mode the hit flags that forward mode returned, on the same address sequence from a cleared state, reproduces the original outcomes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; starts a wipe |
| clr_i | input | 1 | Synchronous clear of table and history |
| req_valid_i | input | 1 | Request present |
| req_mode_i | input | 1 | 0 = forward (outcome in), 1 = inverse (hit in) |
| req_pc_i | input | PC_W | Branch address |
| req_bit_i | input | 1 | Outcome (forward) or hit flag (inverse) |
| req_ready_o | output | 1 | Request can be taken this cycle |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_bit_o | output | 1 | Hit flag (forward) or rebuilt outcome (inverse) |

## Verification
The bench first trains one entry up to a counter value of 2 through aliasing addresses, then flushes the history back to zero. It then sends two back-to-back not-taken requests to that same address. A design without the same-index stall would read the stale value 2 for the second request and report a miss instead of a hit. A second pair differs only in history, so it must be accepted without a bubble; a design that stalls there loses a cycle, and one that forwards no history reads the wrong entry.

Runs of repeated not-taken and taken outcomes expose counters that wrap instead of saturating, since a wrapped counter flips the prediction. A clear issued while a request is in flight must give no response, must hold ready low for the exact walk length, and must ignore requests presented during the walk. The encode-then-decode round trip catches any difference between how the two modes train the table.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
    localparam int CTR_W = 2;

    typedef enum logic [1:0] {
        ST_WIPE = 2'd0,
        ST_IDLE = 2'd1,
        ST_LOOK = 2'd2
    } bpg_state_e;

    typedef enum logic {
        MODE_FWD = 1'b0,
        MODE_INV = 1'b1
    } bpg_mode_e;
endpackage

// File: rtl/bpg_hash.sv
module bpg_hash #(
    parameter int PC_W   = 32,
    parameter int IDX_W  = 10,
    parameter int HIST_W = 12
) (
    input  logic [PC_W-1:0]   pc_i,
    input  logic [HIST_W-1:0] hist_i,
    output logic [IDX_W-1:0]  idx_o
);
    localparam int W = (IDX_W > HIST_W + 2) ? IDX_W : HIST_W + 2;

    logic [W-1:0] pc_word;
    logic [W-1:0] hist_sh;

    always_comb begin
        pc_word = W'(pc_i >> 2);
        hist_sh = W'(hist_i) << 2;
        idx_o   = pc_word[IDX_W-1:0] ^ hist_sh[IDX_W-1:0];
    end
endmodule

// File: rtl/bpg_table.sv
module bpg_table #(
    parameter int IDX_W = 10,
    parameter int DW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [DW-1:0]    rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [DW-1:0]    wr_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        if (rd_en) begin
            rd_q <= mem[rd_addr];
        end
    end

    assign rd_data = rd_q;

    // R8: the controller must never read an entry in the cycle it is rewritten
    assert_no_rw_collision_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en && (rd_addr == wr_addr)));
endmodule

// File: rtl/bpg_resolve.sv
module bpg_resolve
    import bpg_pkg::*;
(
    input  logic [CTR_W-1:0] ctr_i,
    input  bpg_mode_e        mode_i,
    input  logic             bit_i,
    output logic             outcome_o,
    output logic             rsp_o,
    output logic [CTR_W-1:0] ctr_o
);
    localparam logic [CTR_W-1:0] CTR_MAX = '1;

    logic pred;
    logic agree;

    always_comb begin
        pred  = ctr_i[CTR_W-1];
        agree = (pred == bit_i);
        unique case (mode_i)
            MODE_FWD: begin
                outcome_o = bit_i;
                rsp_o     = agree;
            end
            MODE_INV: begin
                outcome_o = agree;
                rsp_o     = agree;
            end
            default: begin
                outcome_o = bit_i;
                rsp_o     = agree;
            end
        endcase
        if (outcome_o) begin
            ctr_o = (ctr_i == CTR_MAX) ? ctr_i : CTR_W'(ctr_i + CTR_W'(1));
        end else begin
            ctr_o = (ctr_i == '0) ? ctr_i : CTR_W'(ctr_i - CTR_W'(1));
        end
    end
endmodule

// File: rtl/bp_gshare_dual.sv
module bp_gshare_dual
    import bpg_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int IDX_W  = 10,
    parameter int HIST_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            req_valid_i,
    input  logic            req_mode_i,
    input  logic [PC_W-1:0] req_pc_i,
    input  logic            req_bit_i,
    output logic            req_ready_o,
    output logic            rsp_valid_o,
    output logic            rsp_bit_o
);
    localparam logic [IDX_W-1:0] WIPE_LAST = '1;

    bpg_state_e        st_q, st_d;
    logic [IDX_W-1:0]  wipe_q;
    logic [HIST_W-1:0] ghr_q;
    logic [HIST_W-1:0] ghr_fwd;
    logic [IDX_W-1:0]  s1_idx_q;
    bpg_mode_e         s1_mode_q;
    logic              s1_bit_q;
    logic              rsp_valid_q;
    logic              rsp_bit_q;

    logic [IDX_W-1:0]  new_idx;
    logic              hazard;
    logic              accept;
    logic              in_look;

    logic              tbl_we;
    logic [IDX_W-1:0]  tbl_waddr;
    logic [CTR_W-1:0]  tbl_wdata;
    logic [CTR_W-1:0]  tbl_rdata;

    logic              res_outcome;
    logic              res_rsp;
    logic [CTR_W-1:0]  res_ctr;

    bpg_resolve u_resolve (
        .ctr_i     (tbl_rdata),
        .mode_i    (s1_mode_q),
        .bit_i     (s1_bit_q),
        .outcome_o (res_outcome),
        .rsp_o     (res_rsp),
        .ctr_o     (res_ctr)
    );

    // history as seen by the next request: forward the outcome being resolved
    always_comb begin
        in_look = (st_q == ST_LOOK);
        ghr_fwd = in_look ? {ghr_q[HIST_W-2:0], res_outcome} : ghr_q;
    end

    bpg_hash #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_hash (
        .pc_i   (req_pc_i),
        .hist_i (ghr_fwd),
        .idx_o  (new_idx)
    );

    always_comb begin
        hazard      = in_look && (new_idx == s1_idx_q);
        req_ready_o = (st_q != ST_WIPE) && !clr_i && !hazard;
        accept      = req_valid_i && req_ready_o;
        tbl_we      = (st_q == ST_WIPE) || (in_look && !clr_i);
        tbl_waddr   = (st_q == ST_WIPE) ? wipe_q : s1_idx_q;
        tbl_wdata   = (st_q == ST_WIPE) ? '0 : res_ctr;
    end

    bpg_table #(.IDX_W(IDX_W), .DW(CTR_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (accept),
        .rd_addr (new_idx),
        .rd_data (tbl_rdata),
        .wr_en   (tbl_we),
        .wr_addr (tbl_waddr),
        .wr_data (tbl_wdata)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d = ST_WIPE;
        end else begin
            unique case (st_q)
                ST_WIPE: if (wipe_q == WIPE_LAST) st_d = ST_IDLE;
                ST_IDLE: if (accept) st_d = ST_LOOK;
                ST_LOOK: st_d = accept ? ST_LOOK : ST_IDLE;
                default: st_d = ST_WIPE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_WIPE;
        end else begin
            st_q <= st_d;
        end
    end

    // datapath registers: wipe pointer, history, in-flight request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wipe_q    <= '0;
            ghr_q     <= '0;
            s1_idx_q  <= '0;
            s1_mode_q <= MODE_FWD;
            s1_bit_q  <= 1'b0;
        end else begin
            if (clr_i) begin
                wipe_q <= '0;
            end else if (st_q == ST_WIPE) begin
                wipe_q <= wipe_q + IDX_W'(1);
            end
            if (clr_i || (st_q == ST_WIPE)) begin
                ghr_q <= '0;
            end else if (in_look) begin
                ghr_q <= ghr_fwd;
            end
            if (accept) begin
                s1_idx_q  <= new_idx;
                s1_mode_q <= bpg_mode_e'(req_mode_i);
                s1_bit_q  <= req_bit_i;
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_bit_q   <= 1'b0;
        end else begin
            rsp_valid_q <= in_look && !clr_i;
            rsp_bit_q   <= in_look ? res_rsp : 1'b0;
        end
    end

    assign rsp_valid_o = rsp_valid_q;
    assign rsp_bit_o   = rsp_bit_q;

    // R1: a sampled clear shuts the request port in the next cycle
    assert_clr_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !req_ready_o);

    // R1: the walk writes zeros every cycle it runs
    assert_wipe_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WIPE) |-> (tbl_we && (tbl_wdata == '0)));

    // R3: a resolved counter moves by at most one step in the outcome's direction
    assert_ctr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_look && !clr_i) |->
            (res_outcome ? ((tbl_wdata == tbl_rdata) || (tbl_wdata == CTR_W'(tbl_rdata + CTR_W'(1))))
                         : ((tbl_wdata == tbl_rdata) || (tbl_wdata == CTR_W'(tbl_rdata - CTR_W'(1))))));

    // R6: the history takes in the resolved outcome
    assert_hist_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_look && !clr_i) |=> (ghr_q[0] == $past(res_outcome)));

    // R7: an accepted request answers two edges later
    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
        (req_valid_i && req_ready_o) |=> ##1 rsp_valid_o);

    // R10: no response follows a cycle in which a clear was sampled
    assert_no_rsp_after_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> !$past(clr_i));
endmodule

// File: tb/bp_gshare_dual_bench.sv
`timescale 1ns/1ps
module bp_gshare_dual_bench;
    localparam int PC_W   = 32;
    localparam int IDX_W  = 10;
    localparam int HIST_W = 12;
    localparam int DEPTH  = 1 << IDX_W;

    // {mode, bit, pc[15:0]}
    localparam logic [17:0] VEC [16] = '{
        {1'b0, 1'b1, 16'h0100}, {1'b0, 1'b1, 16'h0100}, {1'b0, 1'b0, 16'h0104},
        {1'b1, 1'b1, 16'h0108}, {1'b0, 1'b1, 16'h0100}, {1'b1, 1'b0, 16'h2230},
        {1'b0, 1'b0, 16'h2230}, {1'b0, 1'b1, 16'h0FFC}, {1'b1, 1'b1, 16'h0FFC},
        {1'b1, 1'b1, 16'h0100}, {1'b0, 1'b1, 16'h4A48}, {1'b0, 1'b1, 16'h4A48},
        {1'b1, 1'b0, 16'h0104}, {1'b0, 1'b0, 16'h7770}, {1'b1, 1'b1, 16'h0040},
        {1'b0, 1'b1, 16'h0040}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            clr_i = 1'b0;
    logic            req_valid_i = 1'b0;
    logic            req_mode_i = 1'b0;
    logic [PC_W-1:0] req_pc_i = '0;
    logic            req_bit_i = 1'b0;
    logic            req_ready_o;
    logic            rsp_valid_o;
    logic            rsp_bit_o;

    int n_chk = 0;
    int n_err = 0;
    int mdl_ctr [DEPTH];
    logic [HIST_W-1:0] mdl_ghr;

    always #10 clk = ~clk;

    bp_gshare_dual #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_bp_gshare_dual (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr_i),
        .req_valid_i (req_valid_i),
        .req_mode_i  (req_mode_i),
        .req_pc_i    (req_pc_i),
        .req_bit_i   (req_bit_i),
        .req_ready_o (req_ready_o),
        .rsp_valid_o (rsp_valid_o),
        .rsp_bit_o   (rsp_bit_o)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic mdl_clear();
        for (int i = 0; i < DEPTH; i++) mdl_ctr[i] = 0;
        mdl_ghr = '0;
    endtask

    task automatic mdl_step(input logic m, input logic [PC_W-1:0] pc, input logic b, output int rsp);
        int idx;
        int pred;
        int outc;
        idx  = ((pc >> 2) ^ (int'(mdl_ghr) << 2)) & (DEPTH - 1);
        pred = mdl_ctr[idx] >> 1;
        if (m) begin
            outc = (pred == int'(b)) ? 1 : 0;
            rsp  = outc;
        end else begin
            outc = int'(b);
            rsp  = (pred == int'(b)) ? 1 : 0;
        end
        if (outc == 1) begin
            if (mdl_ctr[idx] < 3) mdl_ctr[idx]++;
        end else begin
            if (mdl_ctr[idx] > 0) mdl_ctr[idx]--;
        end
        mdl_ghr = {mdl_ghr[HIST_W-2:0], outc[0]};
    endtask

    // count walk cycles starting at the negedge after the clear edge
    task automatic wait_wipe(input string what, output bit saw_rsp);
        int lows;
        lows = 0;
        saw_rsp = 0;
        while (!req_ready_o) begin
            lows++;
            if (rsp_valid_o) saw_rsp = 1;
            @(negedge clk);
        end
        chk(lows == DEPTH, what, lows, DEPTH);
        mdl_clear();
    endtask

    task automatic do_clear();
        bit s;
        @(negedge clk);
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        wait_wipe("R1 clear walk length", s);
    endtask

    task automatic issue(input logic m, input logic [PC_W-1:0] pc, input logic b,
                         input string tag, output logic got);
        int exp_r;
        @(negedge clk);
        req_valid_i = 1'b1;
        req_mode_i  = m;
        req_pc_i    = pc;
        req_bit_i   = b;
        while (!req_ready_o) @(negedge clk);
        @(negedge clk);
        req_valid_i = 1'b0;
        mdl_step(m, pc, b, exp_r);
        @(negedge clk);
        chk(rsp_valid_o == 1'b1, {tag, " R7 response pulse"}, int'(rsp_valid_o), 1);
        chk(int'(rsp_bit_o) == exp_r, tag, int'(rsp_bit_o), exp_r);
        got = rsp_bit_o;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic g;
        bit saw;
        logic hits [16];
        int exp_a;
        int exp_b;

        mdl_clear();
        // reset state
        repeat (3) @(negedge clk);
        chk(req_ready_o == 1'b0, "R1 ready low in reset", int'(req_ready_o), 0);
        chk(rsp_valid_o == 1'b0, "R7 no response in reset", int'(rsp_valid_o), 0);
        rst_n = 1'b1;
        wait_wipe("R1 reset walk length", saw);

        // R3 low saturation: not-taken keeps history 0, counter must stay 0
        for (int i = 0; i < 4; i++) issue(1'b0, 32'h0000_0000, 1'b0, "R3 floor", g);
        // R3 high saturation after long taken run
        for (int i = 0; i < 20; i++) issue(1'b0, 32'h0000_0200, 1'b1, "R3 ceiling", g);

        // table-driven walk, R2 R4 R5 R6
        do_clear();
        for (int p = 0; p < 3; p++) begin
            for (int i = 0; i < 16; i++) begin
                issue(VEC[i][17], {16'h0, VEC[i][15:0] ^ 16'(p * 16'h0124)}, VEC[i][16],
                      "R2 R4 R5 R6 vector", g);
            end
        end

        // R8 same-index stall: build counter 2 at index 0x10 with history 0
        do_clear();
        issue(1'b0, 32'h0000_0400, 1'b1, "R8 setup", g);
        issue(1'b0, 32'h0000_0050, 1'b1, "R8 setup", g);
        issue(1'b0, 32'h0000_0070, 1'b1, "R8 setup", g);
        for (int i = 0; i < 12; i++) issue(1'b0, 32'h0000_0800, 1'b0, "R8 setup", g);
        @(negedge clk);
        req_valid_i = 1'b1; req_mode_i = 1'b0; req_pc_i = 32'h40; req_bit_i = 1'b0;
        while (!req_ready_o) @(negedge clk);
        @(negedge clk);
        mdl_step(1'b0, 32'h40, 1'b0, exp_a);
        #1;
        chk(req_ready_o == 1'b0, "R8 same index held off", int'(req_ready_o), 0);
        @(negedge clk);
        chk(rsp_valid_o == 1'b1, "R7 first of pair", int'(rsp_valid_o), 1);
        chk(int'(rsp_bit_o) == exp_a, "R8 first of pair", int'(rsp_bit_o), exp_a);
        chk(req_ready_o == 1'b1, "R8 ready after write", int'(req_ready_o), 1);
        mdl_step(1'b0, 32'h40, 1'b0, exp_b);
        @(negedge clk);
        req_valid_i = 1'b0;
        chk(rsp_valid_o == 1'b0, "R7 no response in stall bubble", int'(rsp_valid_o), 0);
        @(negedge clk);
        chk(rsp_valid_o == 1'b1, "R7 second of pair", int'(rsp_valid_o), 1);
        chk(int'(rsp_bit_o) == exp_b, "R8 second reads updated counter", int'(rsp_bit_o), exp_b);

        // R8 back-to-back with differing index (history now 0, first outcome 1)
        @(negedge clk);
        req_valid_i = 1'b1; req_mode_i = 1'b0; req_pc_i = 32'h100; req_bit_i = 1'b1;
        while (!req_ready_o) @(negedge clk);
        @(negedge clk);
        mdl_step(1'b0, 32'h100, 1'b1, exp_a);
        req_bit_i = 1'b0;
        #1;
        chk(req_ready_o == 1'b1, "R8 different index accepted at once", int'(req_ready_o), 1);
        @(negedge clk);
        req_valid_i = 1'b0;
        mdl_step(1'b0, 32'h100, 1'b0, exp_b);
        chk(int'(rsp_bit_o) == exp_a, "R2 back-to-back first", int'(rsp_bit_o), exp_a);
        @(negedge clk);
        chk(rsp_valid_o == 1'b1, "R7 back-to-back second", int'(rsp_valid_o), 1);
        chk(int'(rsp_bit_o) == exp_b, "R2 back-to-back second uses forwarded history",
            int'(rsp_bit_o), exp_b);

        // R10 clear squashes the in-flight request
        @(negedge clk);
        req_valid_i = 1'b1; req_mode_i = 1'b0; req_pc_i = 32'h200; req_bit_i = 1'b1;
        while (!req_ready_o) @(negedge clk);
        @(negedge clk);
        req_valid_i = 1'b0;
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        chk(rsp_valid_o == 1'b0, "R10 squashed request answered", int'(rsp_valid_o), 0);
        wait_wipe("R10 walk after squash", saw);
        chk(saw == 1'b0, "R10 response during walk", int'(saw), 0);
        issue(1'b0, 32'h200, 1'b1, "R10 table empty after squash", g);

        // R9 requests during the walk are ignored
        @(negedge clk);
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        req_valid_i = 1'b1; req_mode_i = 1'b0; req_pc_i = 32'h300; req_bit_i = 1'b1;
        wait_wipe("R9 walk with requests pending", saw);
        req_valid_i = 1'b0;
        chk(saw == 1'b0, "R9 response to ignored request", int'(saw), 0);
        issue(1'b0, 32'h300, 1'b1, "R9 no training from ignored request", g);
        chk(g == 1'b0, "R9 counter untouched", int'(g), 0);

        // R11 encode then decode
        do_clear();
        for (int i = 0; i < 16; i++) begin
            issue(1'b0, {16'h0, VEC[i][15:0]}, VEC[i][16], "R11 encode", g);
            hits[i] = g;
        end
        do_clear();
        for (int i = 0; i < 16; i++) begin
            issue(1'b1, {16'h0, VEC[i][15:0]}, hits[i], "R11 decode", g);
            chk(g == VEC[i][16], "R11 outcome rebuilt", int'(g), int'(VEC[i][16]));
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule